// File: doc/BRIEF.md
# Single-Source Interrupt Admission Controller

This block sits beside a processor core's trap logic and decides, in each cycle, whether the core may take its one external interrupt request. The decision is combinational. A grant appears in the same cycle as the request, as long as the global machine interrupt enable is high and no handler is active. The block keeps two busy flags. One marks a running interrupt handler and the other a running exception handler. A return-from-trap pulse clears these flags, and when that pulse ends an interrupt handler the block raises a return-from-interrupt strobe.

An exception taken inside an interrupt handler is unwound in two steps. The first return clears only the exception flag and does not raise the strobe. The second return ends the interrupt, raises the strobe, and opens the block to new requests. The block also drives a fixed cause word. Its top bit marks an interrupt and its low bits carry the cause code. The core's register file uses this word when it records the trap.

Top module: `single_irq_gate`

## Requirements
- R1: The grant output is high in the same cycle as the request when the request is high, the enable is high, the exception pulse is low and neither busy flag is set.
- R2: While the enable is low, a request is never granted. Raising the enable later lets a waiting request be granted.
- R3: A grant sets the interrupt busy flag at the next clock edge. Until a return clears that flag, further requests get no grant.
- R4: An exception pulse sets the exception busy flag at the next clock edge, so a request in the following cycle gets no grant.
- R5: When an exception pulse and a request arrive in the same cycle, the grant stays low.
- R6: A return pulse while only the interrupt busy flag is set raises the return strobe in that same cycle and clears the interrupt flag. A request in the next cycle is then granted.
- R7: A return pulse while the exception busy flag is set clears only that flag, and the return strobe stays low.
- R8: After an exception nested in an interrupt handler, the first return leaves requests refused. The second return raises the strobe, and after it a request is granted.
- R9: The cause output is constant 0x8000_0010. Bit 31 is set to mark an interrupt and the low bits hold cause code 16.
- R10: Reset is synchronous and active high. Two or more cycles of reset clear both busy flags, so a request right after reset is granted.
- R11: When an exception pulse and a return pulse arrive in the same cycle, the exception busy flag ends up set, so a following request is refused.
- R12: A return pulse while no handler is active raises no strobe and changes nothing, so a following request is still granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exc_pulse | input | 1 | An exception is taken in this cycle |
| req_lvl | input | 1 | External interrupt request level |
| ret_pulse | input | 1 | A return-from-trap instruction retires in this cycle |
| glob_en | input | 1 | Global machine interrupt enable |
| grant_o | output | 1 | Interrupt taken in this cycle (combinational) |
| irq_ret_o | output | 1 | The return ends the interrupt handler (combinational) |
| cause_o | output | 32 | Fixed cause word |

## Verification
The hardest state to reach is the nested one, in which an exception is active inside an interrupt handler. It is reached only through a grant followed by an exception pulse in the next cycle. The bench then sends returns one at a time and probes with a request after each, which tells the first return apart from the second. A collision between an exception and a return is also hard to see at the ports. The bench provokes it while the exception flag is already set, then sends a request so that the flag's final value shows in the grant.

// File: rtl/single_irq_gate_pkg.sv
package single_irq_gate_pkg;
   typedef enum logic {
      PRIO_SET = 1'b0,
      PRIO_CLR = 1'b1
   } flag_prio_e;

   localparam int unsigned DEF_CAUSE_W    = 32;
   localparam int unsigned DEF_CAUSE_CODE = 16;
endpackage

// File: rtl/hold_flag.sv
module hold_flag
   import single_irq_gate_pkg::*;
#(
   parameter flag_prio_e PRIO = PRIO_SET
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic q_r;

   generate
      if (PRIO == PRIO_SET) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (rst)      q_r <= 1'b0;
            else if (set) q_r <= 1'b1;
            else if (clr) q_r <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (rst)      q_r <= 1'b0;
            else if (clr) q_r <= 1'b0;
            else if (set) q_r <= 1'b1;
         end
      end
   endgenerate

   assign q = q_r;
endmodule

// File: rtl/admit_logic.sv
module admit_logic (
   input  logic req_lvl,
   input  logic glob_en,
   input  logic exc_pulse,
   input  logic ret_pulse,
   input  logic irq_busy,
   input  logic exc_busy,
   output logic grant,
   output logic ret_strobe
);
   logic idle;

   always_comb begin
      idle       = !irq_busy && !exc_busy;
      grant      = req_lvl && glob_en && idle && !exc_pulse;
      ret_strobe = ret_pulse && irq_busy && !exc_busy;
   end
endmodule

// File: rtl/cause_word.sv
module cause_word #(
   parameter int unsigned W    = 32,
   parameter int unsigned CODE = 16
) (
   output logic [W-1:0] word
);
   localparam int unsigned CODE_W = W - 1;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("cause_word: width must be 2..32");
      end
      if ((CODE >> CODE_W) != 0) begin : g_bad_code
         $error("cause_word: code does not fit below the interrupt bit");
      end
   endgenerate

   localparam logic [CODE_W-1:0] CODE_V = CODE[CODE_W-1:0];

   assign word = {1'b1, CODE_V};
endmodule

// File: rtl/single_irq_gate.sv
module single_irq_gate
   import single_irq_gate_pkg::*;
#(
   parameter int unsigned CAUSE_W    = DEF_CAUSE_W,
   parameter int unsigned CAUSE_CODE = DEF_CAUSE_CODE
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               exc_pulse,
   input  logic               req_lvl,
   input  logic               ret_pulse,
   input  logic               glob_en,
   output logic               grant_o,
   output logic               irq_ret_o,
   output logic [CAUSE_W-1:0] cause_o
);
   logic irq_busy_q;
   logic exc_busy_q;
   logic grant_w;
   logic strobe_w;

   admit_logic u_admit (
      .req_lvl   (req_lvl),
      .glob_en   (glob_en),
      .exc_pulse (exc_pulse),
      .ret_pulse (ret_pulse),
      .irq_busy  (irq_busy_q),
      .exc_busy  (exc_busy_q),
      .grant     (grant_w),
      .ret_strobe(strobe_w)
   );

   hold_flag #(.PRIO(PRIO_SET)) u_irq_flag (
      .clk(clk), .rst(rst), .set(grant_w), .clr(strobe_w), .q(irq_busy_q)
   );

   hold_flag #(.PRIO(PRIO_SET)) u_exc_flag (
      .clk(clk), .rst(rst), .set(exc_pulse), .clr(ret_pulse), .q(exc_busy_q)
   );

   cause_word #(.W(CAUSE_W), .CODE(CAUSE_CODE)) u_cause (
      .word(cause_o)
   );

   assign grant_o   = grant_w;
   assign irq_ret_o = strobe_w;
endmodule

// File: rtl/single_irq_gate_chk.sv
module single_irq_gate_chk (
   input logic clk,
   input logic rst,
   input logic exc_pulse,
   input logic req_lvl,
   input logic ret_pulse,
   input logic glob_en,
   input logic grant_o,
   input logic irq_ret_o,
   input logic irq_busy_q,
   input logic exc_busy_q
);
   p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
      grant_o |-> (req_lvl && !irq_busy_q && !exc_busy_q));

   p_no_grant_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      !glob_en |-> !grant_o);

   p_busy_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
      grant_o |=> (irq_busy_q && !grant_o));

   p_exc_blocks_next_r4: assert property (@(posedge clk) disable iff (rst)
      exc_pulse |=> !grant_o);

   p_same_cycle_exc_r5: assert property (@(posedge clk) disable iff (rst)
      exc_pulse |-> !grant_o);

   p_strobe_clears_r6: assert property (@(posedge clk) disable iff (rst)
      irq_ret_o |=> !irq_busy_q);

   p_strobe_source_r7: assert property (@(posedge clk) disable iff (rst)
      irq_ret_o |-> (ret_pulse && !exc_busy_q));

   p_exc_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
      exc_pulse |=> exc_busy_q);

   p_idle_ret_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      !irq_busy_q |-> !irq_ret_o);
endmodule

bind single_irq_gate single_irq_gate_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .exc_pulse (exc_pulse),
   .req_lvl   (req_lvl),
   .ret_pulse (ret_pulse),
   .glob_en   (glob_en),
   .grant_o   (grant_o),
   .irq_ret_o (irq_ret_o),
   .irq_busy_q(irq_busy_q),
   .exc_busy_q(exc_busy_q)
);

// File: tb/single_irq_gate_tb.sv
module single_irq_gate_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        exc_pulse = 1'b0;
   logic        req_lvl = 1'b0;
   logic        ret_pulse = 1'b0;
   logic        glob_en = 1'b0;
   logic        grant_o;
   logic        irq_ret_o;
   logic [31:0] cause_o;

   typedef struct {
      logic  g;
      logic  r;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_errs = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   single_irq_gate dut_i (
      .clk(clk), .rst(rst), .exc_pulse(exc_pulse), .req_lvl(req_lvl),
      .ret_pulse(ret_pulse), .glob_en(glob_en), .grant_o(grant_o),
      .irq_ret_o(irq_ret_o), .cause_o(cause_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errs++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; exc_pulse = 0; req_lvl = 0; ret_pulse = 0; glob_en = 0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input logic e, input logic rq, input logic rt,
                       input logic en, input logic eg, input logic er,
                       input string tag);
      exp_t x;
      @(negedge clk);
      exc_pulse = e; req_lvl = rq; ret_pulse = rt; glob_en = en;
      x.g = eg; x.r = er; x.tag = tag;
      q.push_back(x);
   endtask

   initial begin
      forever begin
         exp_t x;
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            x = q.pop_front();
            chk(x.tag, "grant", {31'd0, grant_o}, {31'd0, x.g});
            chk(x.tag, "ret", {31'd0, irq_ret_o}, {31'd0, x.r});
            chk("R9", "cause", cause_o, 32'h8000_0010);
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      // R10: reset state, request granted right after reset
      do_reset();
      step(0, 0, 0, 1, 0, 0, "R10");
      step(0, 1, 0, 1, 1, 0, "R10");
      // R10: reset while busy clears the flag
      step(0, 1, 0, 1, 0, 0, "R10");
      do_reset();
      step(0, 1, 0, 1, 1, 0, "R10");

      // R1
      do_reset();
      step(0, 1, 0, 1, 1, 0, "R1");

      // R2
      do_reset();
      step(0, 1, 0, 0, 0, 0, "R2");
      step(0, 1, 0, 0, 0, 0, "R2");
      step(0, 1, 0, 1, 1, 0, "R2");

      // R3
      do_reset();
      step(0, 1, 0, 1, 1, 0, "R3");
      step(0, 1, 0, 1, 0, 0, "R3");
      step(0, 1, 0, 1, 0, 0, "R3");

      // R4
      do_reset();
      step(1, 0, 0, 1, 0, 0, "R4");
      step(0, 1, 0, 1, 0, 0, "R4");

      // R5
      do_reset();
      step(1, 1, 0, 1, 0, 0, "R5");
      step(0, 1, 0, 1, 0, 0, "R5");

      // R6
      do_reset();
      step(0, 1, 0, 1, 1, 0, "R6");
      step(0, 0, 1, 1, 0, 1, "R6");
      step(0, 1, 0, 1, 1, 0, "R6");

      // R7
      do_reset();
      step(1, 0, 0, 1, 0, 0, "R7");
      step(0, 0, 1, 1, 0, 0, "R7");
      step(0, 1, 0, 1, 1, 0, "R7");

      // R8: exception nested in interrupt handler
      do_reset();
      step(0, 1, 0, 1, 1, 0, "R8");
      step(1, 0, 0, 1, 0, 0, "R8");
      step(0, 0, 1, 1, 0, 0, "R8");
      step(0, 1, 0, 1, 0, 0, "R8");
      step(0, 0, 1, 1, 0, 1, "R8");
      step(0, 1, 0, 1, 1, 0, "R8");

      // R11: exception and return collide while exception busy
      do_reset();
      step(1, 0, 0, 1, 0, 0, "R11");
      step(1, 0, 1, 1, 0, 0, "R11");
      step(0, 1, 0, 1, 0, 0, "R11");
      step(0, 0, 1, 1, 0, 0, "R11");
      step(0, 1, 0, 1, 1, 0, "R11");

      // R12: return with nothing active
      do_reset();
      step(0, 0, 1, 1, 0, 0, "R12");
      step(0, 1, 0, 1, 1, 0, "R12");

      step(0, 0, 0, 0, 0, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule